// File: doc/BRIEF.md
# Cartridge-Bus DMA Register Controller

This block is the software-visible control side of a DMA engine that moves data between main memory and a cartridge-side bus. It holds a main-memory address, a cartridge address and two length registers, and a status word with a busy flag and a pending flag. A register write to one of the length registers launches a transfer in the direction tied to that register. The block presents the masked addresses, the direction and the rounded byte count to a datapath. The datapath reports the end of the transfer with a single-cycle done pulse.

On completion, both address registers advance by the byte count, busy drops, the pending flag sets and a level interrupt rises. The interrupt stays high until software acknowledges it through a command write to the status slot. If the main-memory address holds the all-ones value when a length register is written, the request completes at once and no transfer is launched. Software uses this to get an interrupt without moving data.

Top module: `cart_dma_ctrl`

## Requirements
- R1: The transfer count is the low 24 bits of the written length value plus one. When a completion is accepted, the main-memory and cartridge address registers each grow by that count, with 32-bit wrap-around.
- R2: `xfer_bytes` is the transfer count rounded up to the next multiple of 8 (a count of 3 gives 8, 0x20 gives 0x20, 0x1000000 gives 0x1000000).
- R3: A length write that is accepted while idle raises `xfer_start` for exactly one cycle, starting on the clock edge that takes the write. From that edge the status word reads 0x9 (bit 0 busy, bit 3 pending), and `irq` stays low.
- R4: A write to word 2 (read length) gives `xfer_dir` = 1, which means main memory to cartridge. A write to word 3 (write length) gives `xfer_dir` = 0, which means cartridge to main memory.
- R5: A `xfer_done` pulse while busy makes the status word read 0x8 and raises `irq` on that edge. `irq` then holds until it is acknowledged.
- R6: A status-slot write with data bit 0 set clears both status bits (the status word reads 0) and leaves `irq` unchanged.
- R7: A status-slot write with data bit 1 set clears status bit 3 and drops `irq` on that edge.
- R8: If the main-memory address register holds 0xFFFFFFFF when a length write is accepted, then `xfer_start` stays low, the status word reads 0x8 and `irq` rises on that edge. The length register still takes the written value.
- R9: At launch, `xfer_mem_addr` carries the low 23 bits of the main-memory address and `xfer_cart_addr` carries the low 28 bits of the cartridge address.
- R10: A write to words 0 to 3 replaces only the bytes whose `reg_be` bit is set. Bit n of `reg_be` covers data bits 8n+7 to 8n.
- R11: Length writes that arrive while busy is set change no register and launch nothing.
- R12: `reg_word` selects the register: 0 main-memory address, 1 cartridge address, 2 read length, 3 write length, 4 status. Other words read 0. `reg_rdata` shows the selected register one cycle after `reg_word` is presented, and a read has no side effect.
- R13: A `xfer_done` pulse while not busy is ignored. Addresses, status and `irq` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_word | input | 3 | Register word offset (byte address bits 4:2) |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Per-byte write enables |
| reg_rdata | output | 32 | Registered read data |
| xfer_start | output | 1 | One-cycle launch pulse to the datapath |
| xfer_dir | output | 1 | 1 = main memory to cartridge, 0 = cartridge to main memory |
| xfer_mem_addr | output | 23 | Main-memory start address for the datapath |
| xfer_cart_addr | output | 28 | Cartridge start address for the datapath |
| xfer_bytes | output | 25 | Byte count rounded up to a multiple of 8 |
| xfer_done | input | 1 | One-cycle completion pulse from the datapath |
| irq | output | 1 | Level interrupt, held until acknowledged |

## Verification
Most state errors in this block become visible at the ports within a cycle or two. A wrong busy flag shows up as a missing or repeated `xfer_start` on the next length write. It also shows up as a status read of 0x9 where 0x8 is expected. A bad count or a bad address advance sits in the address registers until the next readback, which appears on `reg_rdata` one cycle after the word is selected. An interrupt flop that follows the pending bit instead of the completion events is caught at launch, because `irq` must stay low while status reads 0x9.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
  localparam int REG_W = 32;
  localparam int BE_W  = REG_W / 8;

  typedef enum logic [2:0] {
    W_MEM   = 3'd0,
    W_CART  = 3'd1,
    W_RDLEN = 3'd2,
    W_WRLEN = 3'd3,
    W_STAT  = 3'd4
  } reg_word_e;

  localparam int ST_BUSY = 0;
  localparam int ST_PEND = 3;
  localparam int CMD_CLR = 0;
  localparam int CMD_ACK = 1;

  function automatic logic [REG_W-1:0] byte_merge(
    input logic [REG_W-1:0] old_v,
    input logic [REG_W-1:0] new_v,
    input logic [BE_W-1:0]  be
  );
    logic [REG_W-1:0] r;
    r = old_v;
    for (int b = 0; b < BE_W; b++)
      if (be[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/cdma_regfile.sv
module cdma_regfile
  import cdma_pkg::*;
#(
  parameter int CNT_W = 25,
  parameter int NREG  = 4,
  parameter int NADV  = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [2:0]                 idx,
  input  logic [REG_W-1:0]           wdata,
  input  logic [BE_W-1:0]            wbe,
  input  logic                       len_allow,
  input  logic                       adv,
  input  logic [CNT_W-1:0]           adv_cnt,
  output logic [NREG-1:0][REG_W-1:0] q
);
  logic [NREG-1:0] hit;

  always_comb begin
    for (int i = 0; i < NREG; i++)
      hit[i] = wr_en && (idx == 3'(i)) && ((i < NADV) || len_allow);
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g < NADV) begin : g_adv
      always_ff @(posedge clk) begin
        if (rst)          q[g] <= '0;
        else if (hit[g])  q[g] <= byte_merge(q[g], wdata, wbe);
        else if (adv)     q[g] <= q[g] + REG_W'(adv_cnt);
      end
    end else begin : g_len
      always_ff @(posedge clk) begin
        if (rst)          q[g] <= '0;
        else if (hit[g])  q[g] <= byte_merge(q[g], wdata, wbe);
      end
    end
  end

  // R1
  mem_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !hit[0]) |=> q[0] == $past(q[0]) + REG_W'($past(adv_cnt)));

  // R10
  byte_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (hit[1] && !wbe[0] && !adv) |=> q[1][7:0] == $past(q[1][7:0]));
endmodule

// File: rtl/cdma_status.sv
module cdma_status (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic finish,
  input  logic cmd_clr,
  input  logic cmd_ack,
  output logic busy,
  output logic pend,
  output logic irq
);
  logic busy_n, pend_n, irq_n;

  always_comb begin
    busy_n = busy;
    pend_n = pend;
    irq_n  = irq;
    if (start)  begin busy_n = 1'b1; pend_n = 1'b1; end
    if (finish) begin busy_n = 1'b0; pend_n = 1'b1; irq_n = 1'b1; end
    if (cmd_clr) begin busy_n = 1'b0; pend_n = 1'b0; end
    if (cmd_ack) begin pend_n = 1'b0; irq_n = 1'b0; end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      pend <= 1'b0;
      irq  <= 1'b0;
    end else begin
      busy <= busy_n;
      pend <= pend_n;
      irq  <= irq_n;
    end
  end

  // R5
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(finish));
  // R5
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !cmd_ack) |=> irq);
  // R6
  clr_all_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_clr && !finish) |=> (!busy && !pend));
  // R7
  ack_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_ack |=> (!irq && !pend));
endmodule

// File: rtl/cdma_launch.sv
module cdma_launch #(
  parameter int LEN_W     = 24,
  parameter int ALIGN_LG2 = 3,
  parameter int MEM_AW    = 23,
  parameter int CART_AW   = 28,
  localparam int CNT_W    = LEN_W + 1,
  localparam int ALIGN    = 1 << ALIGN_LG2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic               go_dir,
  input  logic [LEN_W-1:0]   len_val,
  input  logic [MEM_AW-1:0]  mem_addr,
  input  logic [CART_AW-1:0] cart_addr,
  output logic               xfer_start,
  output logic               xfer_dir,
  output logic [CNT_W-1:0]   xfer_bytes,
  output logic [MEM_AW-1:0]  xfer_mem_addr,
  output logic [CART_AW-1:0] xfer_cart_addr,
  output logic [CNT_W-1:0]   cnt
);
  logic [CNT_W-1:0] cnt_n, rnd_n;

  assign cnt_n = {1'b0, len_val} + CNT_W'(1);

  if (ALIGN_LG2 > 0) begin : g_round
    assign rnd_n = (cnt_n + CNT_W'(ALIGN - 1)) & ~CNT_W'(ALIGN - 1);
  end else begin : g_exact
    assign rnd_n = cnt_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_start     <= 1'b0;
      xfer_dir       <= 1'b0;
      xfer_bytes     <= '0;
      xfer_mem_addr  <= '0;
      xfer_cart_addr <= '0;
      cnt            <= '0;
    end else begin
      xfer_start <= go;
      if (go) begin
        xfer_dir       <= go_dir;
        xfer_bytes     <= rnd_n;
        xfer_mem_addr  <= mem_addr;
        xfer_cart_addr <= cart_addr;
        cnt            <= cnt_n;
      end
    end
  end

  // R2
  round_range_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> (xfer_bytes >= cnt) && (xfer_bytes - cnt < CNT_W'(ALIGN)));
endmodule

// File: rtl/cart_dma_ctrl.sv
module cart_dma_ctrl
  import cdma_pkg::*;
#(
  parameter int LEN_W     = 24,
  parameter int ALIGN_LG2 = 3,
  parameter int MEM_AW    = 23,
  parameter int CART_AW   = 28,
  localparam int CNT_W    = LEN_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [2:0]         reg_word,
  input  logic [REG_W-1:0]   reg_wdata,
  input  logic [BE_W-1:0]    reg_be,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               xfer_start,
  output logic               xfer_dir,
  output logic [MEM_AW-1:0]  xfer_mem_addr,
  output logic [CART_AW-1:0] xfer_cart_addr,
  output logic [CNT_W-1:0]   xfer_bytes,
  input  logic               xfer_done,
  output logic               irq
);
  logic [3:0][REG_W-1:0] regs;
  logic [REG_W-1:0]      len_new, stat_word;
  logic [CNT_W-1:0]      cnt;
  logic                  busy, pend;
  logic                  len_hit, len_ok, sentinel, go, skip, done_ok;
  logic                  stat_wr;

  assign len_hit  = reg_wr && (reg_word == W_RDLEN || reg_word == W_WRLEN);
  assign len_ok   = len_hit && !busy;
  assign sentinel = (regs[W_MEM] == '1);
  assign go       = len_ok && !sentinel;
  assign skip     = len_ok && sentinel;
  assign done_ok  = xfer_done && busy;
  assign stat_wr  = reg_wr && (reg_word == W_STAT);
  assign len_new  = byte_merge((reg_word == W_RDLEN) ? regs[W_RDLEN] : regs[W_WRLEN],
                               reg_wdata, reg_be);

  cdma_regfile #(.CNT_W(CNT_W), .NREG(4), .NADV(2)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .idx(reg_word), .wdata(reg_wdata),
    .wbe(reg_be), .len_allow(!busy), .adv(done_ok), .adv_cnt(cnt), .q(regs)
  );

  cdma_launch #(.LEN_W(LEN_W), .ALIGN_LG2(ALIGN_LG2), .MEM_AW(MEM_AW),
                .CART_AW(CART_AW)) u_launch (
    .clk(clk), .rst(rst), .go(go), .go_dir(reg_word == W_RDLEN),
    .len_val(len_new[LEN_W-1:0]), .mem_addr(regs[W_MEM][MEM_AW-1:0]),
    .cart_addr(regs[W_CART][CART_AW-1:0]), .xfer_start(xfer_start),
    .xfer_dir(xfer_dir), .xfer_bytes(xfer_bytes), .xfer_mem_addr(xfer_mem_addr),
    .xfer_cart_addr(xfer_cart_addr), .cnt(cnt)
  );

  cdma_status u_stat (
    .clk(clk), .rst(rst), .start(go), .finish(skip || done_ok),
    .cmd_clr(stat_wr && reg_wdata[CMD_CLR]), .cmd_ack(stat_wr && reg_wdata[CMD_ACK]),
    .busy(busy), .pend(pend), .irq(irq)
  );

  always_comb begin
    stat_word          = '0;
    stat_word[ST_BUSY] = busy;
    stat_word[ST_PEND] = pend;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_word)
        W_MEM, W_CART, W_RDLEN, W_WRLEN: reg_rdata <= regs[reg_word[1:0]];
        W_STAT:                          reg_rdata <= stat_word;
        default:                         reg_rdata <= '0;
      endcase
    end
  end

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> (busy && !irq));
  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> !xfer_start);
  // R8
  sentinel_chk: assert property (@(posedge clk) disable iff (rst)
    skip |=> (!xfer_start && irq && !busy));
  // R11
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    (len_hit && busy) |=> ($stable(regs[W_RDLEN]) && $stable(regs[W_WRLEN]) && !xfer_start));
  // R9
  launch_addr_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> (xfer_mem_addr == regs[W_MEM][MEM_AW-1:0]));
  // R13
  idle_done_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && !busy && !reg_wr) |=> ($stable(regs[W_MEM]) && $stable(irq)));
endmodule

// File: tb/cart_dma_ctrl_bench.sv
`timescale 1ns/1ps
module cart_dma_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_word = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_rdata;
  logic        xfer_start, xfer_dir, xfer_done = 1'b0, irq;
  logic [22:0] xfer_mem_addr;
  logic [27:0] xfer_cart_addr;
  logic [24:0] xfer_bytes;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cart_dma_ctrl u_cart_dma_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_word(reg_word), .reg_wdata(reg_wdata),
    .reg_be(reg_be), .reg_rdata(reg_rdata), .xfer_start(xfer_start), .xfer_dir(xfer_dir),
    .xfer_mem_addr(xfer_mem_addr), .xfer_cart_addr(xfer_cart_addr), .xfer_bytes(xfer_bytes),
    .xfer_done(xfer_done), .irq(irq)
  );

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = n[b*8 +: 8];
    return r;
  endfunction
  function automatic logic [31:0] count_of(input logic [31:0] len);
    return {8'h0, len[23:0]} + 32'd1;
  endfunction
  function automatic logic [31:0] round8(input logic [31:0] c);
    return (c + 32'd7) & ~32'd7;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask
  task automatic wr(input logic [2:0] w, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reg_wr = 1'b1; reg_word = w; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask
  task automatic rd(input logic [2:0] w, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_word = w;
    @(negedge clk);
    check(tag, reg_rdata, exp);
  endtask
  task automatic pulse_done();
    @(negedge clk);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask
  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] m_mem, m_cart, len, cnt;
    logic dir;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check("R12 reset irq", 32'(irq), 0);
    check("R12 reset start", 32'(xfer_start), 0);
    rd(3'd4, 32'h0, "R12 reset status");
    rd(3'd0, 32'h0, "R12 reset mem");
    rd(3'd6, 32'h0, "R12 unmapped word");

    // R10 byte merge
    wr(3'd1, 32'h11223344, 4'hF);
    wr(3'd1, 32'hAABBCCDD, 4'b0101);
    rd(3'd1, 32'h11BB33DD, "R10 merge");

    // directed launch, read direction
    wr(3'd0, 32'h00C00010, 4'hF);
    wr(3'd1, 32'hF0000100, 4'hF);
    wr(3'd2, 32'hAB000002, 4'hF);
    check("R3 start pulse", 32'(xfer_start), 1);
    check("R4 dir read", 32'(xfer_dir), 1);
    check("R2 round 3->8", 32'(xfer_bytes), 8);
    check("R9 mem addr", 32'(xfer_mem_addr), 32'h00400010);
    check("R9 cart addr", 32'(xfer_cart_addr), 32'h00000100);
    check("R3 irq low", 32'(irq), 0);
    @(negedge clk);
    check("R3 single pulse", 32'(xfer_start), 0);
    rd(3'd4, 32'h9, "R3 status busy");
    // R11 ignored while busy
    wr(3'd3, 32'h00000055, 4'hF);
    check("R11 no start", 32'(xfer_start), 0);
    rd(3'd3, 32'h0, "R11 len unchanged");
    pulse_done();
    check("R5 irq up", 32'(irq), 1);
    rd(3'd4, 32'h8, "R5 status done");
    rd(3'd0, 32'h00C00013, "R1 mem advance");
    rd(3'd1, 32'hF0000103, "R1 cart advance");
    repeat (5) @(negedge clk);
    check("R5 irq held", 32'(irq), 1);
    wr(3'd4, 32'h1, 4'hF);
    check("R6 irq kept", 32'(irq), 1);
    rd(3'd4, 32'h0, "R6 status cleared");
    wr(3'd4, 32'h2, 4'hF);
    check("R7 irq dropped", 32'(irq), 0);
    // R13 stray done
    pulse_done();
    check("R13 irq idle", 32'(irq), 0);
    rd(3'd0, 32'h00C00013, "R13 mem idle");
    rd(3'd4, 32'h0, "R13 status idle");

    // write direction
    wr(3'd3, 32'h0000001F, 4'hF);
    check("R4 dir write", 32'(xfer_dir), 0);
    check("R2 exact 0x20", 32'(xfer_bytes), 32'h20);
    pulse_done();
    rd(3'd0, 32'h00C00033, "R1 mem advance 2");
    wr(3'd4, 32'h2, 4'hF);
    rd(3'd4, 32'h0, "R7 pend cleared");

    // max length
    wr(3'd0, 32'h0, 4'hF);
    wr(3'd3, 32'h00FFFFFF, 4'hF);
    check("R2 max bytes", 32'(xfer_bytes), 32'h01000000);
    pulse_done();
    rd(3'd0, 32'h01000000, "R1 max advance");
    wr(3'd4, 32'h3, 4'hF);
    check("R7 both cmds irq", 32'(irq), 0);
    rd(3'd4, 32'h0, "R6 both cmds status");

    // wrap
    wr(3'd0, 32'h00800000, 4'hF);
    wr(3'd1, 32'hFFFFFFF8, 4'hF);
    wr(3'd2, 32'h00000007, 4'hF);
    check("R9 mem mask", 32'(xfer_mem_addr), 0);
    check("R9 cart mask", 32'(xfer_cart_addr), 32'h0FFFFFF8);
    pulse_done();
    rd(3'd1, 32'h0, "R1 cart wrap");
    rd(3'd0, 32'h00800008, "R1 mem wrap");
    wr(3'd4, 32'h2, 4'hF);

    // sentinel
    wr(3'd0, 32'hFFFFFFFF, 4'hF);
    wr(3'd2, 32'h00000010, 4'hF);
    check("R8 no start", 32'(xfer_start), 0);
    check("R8 irq", 32'(irq), 1);
    rd(3'd4, 32'h8, "R8 status");
    rd(3'd2, 32'h10, "R8 len stored");
    wr(3'd4, 32'h2, 4'hF);

    // random
    for (int i = 0; i < 24; i++) begin
      m_mem  = $urandom() & 32'h7FFFFFFF;
      m_cart = $urandom();
      len    = $urandom();
      if (i % 4 == 0) len = len & 32'hFF00000F;
      dir    = 1'($urandom() & 1);
      cnt    = count_of(len);
      wr(3'd0, m_mem, 4'hF);
      wr(3'd1, m_cart, 4'hF);
      wr(dir ? 3'd2 : 3'd3, len, 4'hF);
      check("R3 rand start", 32'(xfer_start), 1);
      check("R4 rand dir", 32'(xfer_dir), 32'(dir));
      check("R2 rand bytes", 32'(xfer_bytes), round8(cnt));
      check("R9 rand mem", 32'(xfer_mem_addr), m_mem & 32'h007FFFFF);
      check("R9 rand cart", 32'(xfer_cart_addr), m_cart & 32'h0FFFFFFF);
      rd(3'd4, 32'h9, "R3 rand status");
      repeat ($urandom_range(0, 4)) @(negedge clk);
      pulse_done();
      check("R5 rand irq", 32'(irq), 1);
      rd(3'd0, m_mem + cnt, "R1 rand mem");
      rd(3'd1, m_cart + cnt, "R1 rand cart");
      rd(dir ? 3'd2 : 3'd3, merge(32'h0, len, 4'hF), "R12 rand len read");
      wr(3'd4, 32'h2, 4'hF);
      check("R7 rand ack", 32'(irq), 0);
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule